// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps the most recent virtual-page to physical-frame translations, so that most address translations finish without touching the page tables in memory. A requester presents a virtual page number and says whether the access is a read or a write. One cycle later the block answers with a hit, a miss or a protection fault, and on a hit it also returns the frame number and the protection bits. On a miss, an external table walker performs the two-level walk and installs the result through the fill port.

Every entry compares its tag against the requested page in the same cycle; there is no index-based placement. Each entry stores a tag, a frame number, a protection field, and valid, dirty and global flags. Three maintenance inputs remove entries. The first removes one page. The second removes all non-global entries when the address space changes. The third removes every entry.

Top module: `tlb_cache`

## Requirements
- R1: A lookup request is answered exactly one cycle later: `rsp_valid` is 1 in that cycle and 0 in any cycle that does not follow a request.
- R2: A read lookup whose page matches a valid entry returns `rsp_hit`=1 with that entry's frame and protection bits. A lookup with no matching valid entry returns `rsp_hit`=0, `rsp_fault`=0, and frame and protection both zero.
- R3: A write lookup that matches an entry whose protection bit 0 (write enable) is 0 returns `rsp_fault`=1 and `rsp_hit`=0, with frame zero.
- R4: A write lookup that matches a writable entry whose dirty flag is 0 returns `rsp_hit`=0 and `rsp_fault`=0. A read of the same entry hits.
- R5: A lookup sees the table as it stood before any fill or maintenance input in the same cycle. A fill becomes visible to lookups issued from the next cycle on.
- R6: A fill for a page already present overwrites that entry. No second copy is created, so one single-page invalidate afterwards makes the page miss.
- R7: A fill with no matching entry takes the lowest-numbered invalid entry. When no entry is invalid, it takes the entry at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, only when it is used.
- R8: A single-page invalidate clears the entry that matches its page. The next lookup of that page misses, and other entries keep hitting.
- R9: An address-space flush clears every entry whose global flag is 0. Global entries keep hitting.
- R10: A full flush clears every entry, including global ones.
- R11: Reset clears every valid flag, so every lookup after reset misses. Reset also clears the response outputs.
- R12: When a fill and a maintenance input occur in the same cycle, the maintenance is applied first and the fill is then installed, so the filled page hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number of the translation |
| fill_pfn | input | 20 | Frame number of the translation |
| fill_prot | input | 3 | Protection bits; bit 0 is write enable |
| fill_dirty | input | 1 | Dirty flag of the translation |
| fill_global | input | 1 | Global flag of the translation |
| inv_page_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page to invalidate |
| flush_local | input | 1 | Clear all non-global entries |
| flush_all | input | 1 | Clear all entries |
| rsp_valid | output | 1 | Response present for last cycle's request |
| rsp_hit | output | 1 | Translation usable |
| rsp_fault | output | 1 | Write to a write-protected page |
| rsp_pfn | output | 20 | Frame number on a hit, otherwise zero |
| rsp_prot | output | 3 | Protection bits on a hit, otherwise zero |

## Verification
Two pairs of functions can fall in the same cycle. A lookup can arrive together with a fill, and a fill can arrive together with an invalidate or a flush. The bench drives a fill and a lookup of the same page in one cycle. It expects a miss there and a hit on the lookup that follows. It also drives an invalidate or full flush together with a fill of the same or another page, and then judges the result with later lookups: the filled page must hit and the flushed pages must miss.

// File: rtl/tlb_pkg.sv
// Shared types for the translation cache.
// Assumes: the protection field keeps write enable in bit 0.
package tlb_pkg;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_FAULT = 2'd2
    } lk_res_e;

    // Decide the outcome of a lookup from the matched entry's flags.
    function automatic lk_res_e classify(input logic found, input logic is_write,
                                         input logic wr_en, input logic dirty);
        if (!found)
            return RES_MISS;
        if (is_write && !wr_en)
            return RES_FAULT;
        if (is_write && !dirty)
            return RES_MISS;
        return RES_HIT;
    endfunction

endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare: each valid entry is compared against one key.
// Assumes: at most one entry matches, which the top guarantees on fill.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign any = |hit_vec;

    // Encode the one-hot match into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (hit_vec[i])
                idx = idx | IDX_W'(i);
    end

endmodule

// File: rtl/tlb_victim.sv
// Chooses the entry a fill writes: existing match, else the lowest invalid entry, else the pointer.
// Assumes: the valid vector is the state before this cycle's updates.
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic               same_any,
    input  logic [IDX_W-1:0]   same_idx,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               use_rr
);

    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    // Lowest-numbered invalid entry.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
    end

    // Selection in order of preference.
    always_comb begin
        use_rr = 1'b0;
        if (same_any)
            victim = same_idx;
        else if (free_any)
            victim = free_idx;
        else begin
            victim = rr_ptr;
            use_rr = 1'b1;
        end
    end

endmodule

// File: rtl/tlb_cache.sv
// Fully associative translation cache with global, dirty and write-enable handling.
// Assumes: maintenance in a cycle is applied before that cycle's fill; lookups see old state.
module tlb_cache #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int PROT_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_write,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              fill_dirty,
    input  logic              fill_global,
    input  logic              inv_page_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush_local,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [PROT_W-1:0] rsp_prot
);
    import tlb_pkg::*;

    logic [ENTRIES-1:0]             ent_v, ent_g, ent_d, v_nxt;
    logic [ENTRIES-1:0][VPN_W-1:0]  ent_tag;
    logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
    logic [ENTRIES-1:0][PROT_W-1:0] ent_prot;
    logic [IDX_W-1:0]               rr_ptr;

    logic [ENTRIES-1:0] lk_hitvec, fl_hitvec, inv_hitvec;
    logic               lk_any, fl_any, inv_any;
    logic [IDX_W-1:0]   lk_idx, fl_idx, inv_idx;
    logic [IDX_W-1:0]   victim;
    logic               use_rr;
    lk_res_e            res;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .valid(ent_v), .tags(ent_tag), .key(lk_vpn),
        .hit_vec(lk_hitvec), .any(lk_any), .idx(lk_idx));

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
        .valid(ent_v), .tags(ent_tag), .key(fill_vpn),
        .hit_vec(fl_hitvec), .any(fl_any), .idx(fl_idx));

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_inv_match (
        .valid(ent_v), .tags(ent_tag), .key(inv_vpn),
        .hit_vec(inv_hitvec), .any(inv_any), .idx(inv_idx));

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid(ent_v), .same_any(fl_any), .same_idx(fl_idx),
        .rr_ptr(rr_ptr), .victim(victim), .use_rr(use_rr));

    // Outcome of the current lookup against the stored flags.
    assign res = classify(lk_any, lk_write, ent_prot[lk_idx][0], ent_d[lk_idx]);

    // Next valid vector: maintenance first, then the fill.
    always_comb begin
        v_nxt = ent_v;
        if (flush_all)
            v_nxt = '0;
        else if (flush_local)
            v_nxt = ent_v & ent_g;
        if (inv_page_en && inv_any)
            v_nxt[inv_idx] = 1'b0;
        if (fill_en)
            v_nxt[victim] = 1'b1;
    end

    // Valid flags and replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            rr_ptr <= '0;
        end else begin
            ent_v <= v_nxt;
            if (fill_en && use_rr)
                rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    // Entry payload written by fills.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            ent_tag[victim]  <= fill_vpn;
            ent_pfn[victim]  <= fill_pfn;
            ent_prot[victim] <= fill_prot;
            ent_d[victim]    <= fill_dirty;
            ent_g[victim]    <= fill_global;
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pfn   <= '0;
            rsp_prot  <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && (res == RES_HIT);
            rsp_fault <= lk_req && (res == RES_FAULT);
            rsp_pfn   <= (lk_req && res == RES_HIT) ? ent_pfn[lk_idx] : '0;
            rsp_prot  <= (lk_req && res == RES_HIT) ? ent_prot[lk_idx] : '0;
        end
    end

endmodule

// File: rtl/tlb_checker.sv
// Property checker for the translation cache, attached by bind.
// Assumes: it observes the top's ports plus the valid vector and lookup match vector.
module tlb_checker #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic               lk_write,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic               fill_en,
    input logic               inv_page_en,
    input logic [VPN_W-1:0]   inv_vpn,
    input logic               flush_all,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic [ENTRIES-1:0] ent_v,
    input logic [ENTRIES-1:0] lk_hitvec
);

    logic             inv_pend;
    logic [VPN_W-1:0] inv_q;

    // Remember a lone invalidate from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_pend <= 1'b0;
            inv_q    <= '0;
        end else begin
            inv_pend <= inv_page_en && !fill_en;
            inv_q    <= inv_vpn;
        end
    end

    p_rsp_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_req));

    p_outcome_needs_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_fault) |-> rsp_valid);

    p_hit_fault_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    p_fault_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> $past(lk_write));

    p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hitvec));

    p_inv_then_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_pend && lk_req && lk_vpn == inv_q) |=> !rsp_hit);

    p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !fill_en) |=> (ent_v == '0));

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (ent_v == '0 && !rsp_valid));

endmodule

bind tlb_cache tlb_checker #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_tlb_checker (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_write(lk_write), .lk_vpn(lk_vpn),
    .fill_en(fill_en), .inv_page_en(inv_page_en), .inv_vpn(inv_vpn),
    .flush_all(flush_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .ent_v(ent_v), .lk_hitvec(lk_hitvec));

// File: tb/tb_tlb_cache.sv
module tb_tlb_cache;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req, lk_write, fill_en, fill_dirty, fill_global;
    logic        inv_page_en, flush_local, flush_all;
    logic [19:0] lk_vpn, fill_vpn, fill_pfn, inv_vpn;
    logic [2:0]  fill_prot;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [19:0] rsp_pfn;
    logic [2:0]  rsp_prot;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tlb_cache dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_write(lk_write),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_prot(fill_prot),
        .fill_dirty(fill_dirty), .fill_global(fill_global), .inv_page_en(inv_page_en),
        .inv_vpn(inv_vpn), .flush_local(flush_local), .flush_all(flush_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_pfn(rsp_pfn), .rsp_prot(rsp_prot));

    typedef struct packed {
        logic [1:0]  op;     // 0 fill, 1 read lookup, 2 write lookup
        logic [19:0] vpn;
        logic [19:0] pfn;    // fill frame, or expected frame
        logic [2:0]  prot;   // fill protection, or expected protection
        logic        dirty;
        logic        glob;
        logic        e_hit;
        logic        e_fault;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 20'h00001, 20'h0A001, 3'b101, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd0, 20'h00002, 20'h0B002, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd0, 20'h00003, 20'h0C003, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0},
        '{2'd1, 20'h00001, 20'h0A001, 3'b101, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd2, 20'h00001, 20'h0A001, 3'b101, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd2, 20'h00002, 20'h00000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1},
        '{2'd1, 20'h00002, 20'h0B002, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd2, 20'h00003, 20'h00000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd1, 20'h00003, 20'h0C003, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd1, 20'h00004, 20'h00000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{2'd0, 20'h00001, 20'h0A111, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0},
        '{2'd1, 20'h00001, 20'h0A111, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0}
    };
    localparam string TAG [NV] = '{"R5", "R5", "R5", "R2", "R2", "R3",
                                    "R2", "R4", "R4", "R2", "R6", "R6"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_req = 0; lk_write = 0; lk_vpn = '0;
        fill_en = 0; fill_vpn = '0; fill_pfn = '0; fill_prot = '0;
        fill_dirty = 0; fill_global = 0;
        inv_page_en = 0; inv_vpn = '0; flush_local = 0; flush_all = 0;
    endtask

    task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [2:0] pr,
                           input logic d, input logic g);
        fill_en = 1; fill_vpn = v; fill_pfn = p; fill_prot = pr;
        fill_dirty = d; fill_global = g;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic look(input logic [19:0] v, input logic wr);
        lk_req = 1; lk_vpn = v; lk_write = wr;
        @(negedge clk);
        lk_req = 0; lk_write = 0;
    endtask

    task automatic expect_rsp(input string req, input logic h, input logic f, input logic [19:0] p);
        chk(req, {31'd0, rsp_valid}, 32'd1);
        chk(req, {31'd0, rsp_hit}, {31'd0, h});
        chk(req, {31'd0, rsp_fault}, {31'd0, f});
        chk(req, {12'd0, rsp_pfn}, {12'd0, p});
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        // R11: outputs cleared in reset
        chk("R11", {29'd0, rsp_valid, rsp_hit, rsp_fault}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        look(20'h00001, 0);
        expect_rsp("R11", 0, 0, 20'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].op == 2'd0)
                do_fill(TBL[i].vpn, TBL[i].pfn, TBL[i].prot, TBL[i].dirty, TBL[i].glob);
            else begin
                look(TBL[i].vpn, TBL[i].op == 2'd2);
                expect_rsp(TAG[i], TBL[i].e_hit, TBL[i].e_fault, TBL[i].pfn);
                chk(TAG[i], {29'd0, rsp_prot}, {29'd0, TBL[i].prot});
            end
        end

        // R1: no response in a cycle that follows no request
        @(negedge clk);
        chk("R1", {31'd0, rsp_valid}, 32'd0);

        // R6 / R8: one invalidate removes the overwritten page; others untouched
        inv_page_en = 1; inv_vpn = 20'h00001;
        @(negedge clk);
        inv_page_en = 0;
        look(20'h00001, 0);
        expect_rsp("R6", 0, 0, 20'h0);
        look(20'h00003, 0);
        expect_rsp("R8", 1, 0, 20'h0C003);

        // R9: address-space flush keeps global entries only
        flush_local = 1;
        @(negedge clk);
        flush_local = 0;
        look(20'h00002, 0);
        expect_rsp("R9", 0, 0, 20'h0);
        look(20'h00003, 0);
        expect_rsp("R9", 1, 0, 20'h0C003);

        // R5: fill and lookup of the same page in one cycle
        lk_req = 1; lk_vpn = 20'h00005;
        do_fill(20'h00005, 20'h0E005, 3'b001, 1'b1, 1'b0);
        lk_req = 0;
        expect_rsp("R5", 0, 0, 20'h0);
        look(20'h00005, 1);
        expect_rsp("R5", 1, 0, 20'h0E005);

        // R12: invalidate and refill of the same page together
        inv_page_en = 1; inv_vpn = 20'h00005;
        do_fill(20'h00005, 20'h0E555, 3'b001, 1'b1, 1'b0);
        inv_page_en = 0;
        look(20'h00005, 0);
        expect_rsp("R12", 1, 0, 20'h0E555);

        // R10 / R12: full flush with a fill in the same cycle
        flush_all = 1;
        do_fill(20'h00006, 20'h0F006, 3'b000, 1'b0, 1'b1);
        flush_all = 0;
        look(20'h00003, 0);
        expect_rsp("R10", 0, 0, 20'h0);
        look(20'h00006, 0);
        expect_rsp("R12", 1, 0, 20'h0F006);

        // R7: fill order and round-robin replacement
        flush_all = 1;
        @(negedge clk);
        flush_all = 0;
        for (int k = 0; k < 16; k++)
            do_fill(20'h00100 + 20'(k), 20'h01100 + 20'(k), 3'b001, 1'b1, 1'b0);
        look(20'h0010F, 0);
        expect_rsp("R7", 1, 0, 20'h0110F);
        do_fill(20'h00200, 20'h01200, 3'b001, 1'b1, 1'b0);
        look(20'h00100, 0);
        expect_rsp("R7", 0, 0, 20'h0);
        look(20'h00101, 0);
        expect_rsp("R7", 1, 0, 20'h01101);
        do_fill(20'h00201, 20'h01201, 3'b001, 1'b1, 1'b0);
        look(20'h00101, 0);
        expect_rsp("R7", 0, 0, 20'h0);
        look(20'h00102, 0);
        expect_rsp("R7", 1, 0, 20'h01102);
        look(20'h00200, 0);
        expect_rsp("R7", 1, 0, 20'h01200);

        // R11: reset in mid-run empties the table
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        look(20'h00102, 0);
        expect_rsp("R11", 0, 0, 20'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule